// File: doc/BRIEF.md
# Streaming Base32 Text Decoder

This block turns a stream of Base32 text, one ASCII character per clock, into the binary bytes the text represents. Characters arrive over a valid/ready input. Each legal character stands for a 5-bit group. The groups are joined in arrival order into one bit string, and that string leaves as 8-bit bytes over a valid/ready output.

The first padding character ends the message. Any residue shorter than a byte is discarded at that point, and a one-cycle end marker follows. Characters outside the alphabet, and data characters that arrive after padding, set an error flag that stays set until reset. Those characters do not change the data stream.

A producer feeds text at whatever rate it likes. A consumer may stall the byte output. The decoder stops taking text while a finished byte is waiting, so no bits are lost.

Top module: `b32_stream_decoder`

## Requirements
- R1: Character codes 0x41..0x5A ('A'..'Z') carry the 5-bit values 0..25, and codes 0x32..0x37 ('2'..'7') carry the values 26..31.
- R2: Packing is MSB-first: the first data character of a message supplies bits 7..3 of the first output byte, and each later group follows directly below the previous one.
- R3: A byte is presented on the output whenever at least 8 unconsumed bits are held. Bits beyond that byte are kept for the next byte, so N data characters without padding yield floor(5N/8) bytes.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays unchanged in the next cycle.
- R5: `in_ready` is low whenever a byte is waiting and `out_ready` is low. Under any stall pattern the byte sequence is identical to the unstalled one.
- R6: The first accepted '=' (0x3D) discards the residue of fewer than 8 bits without emitting it, and `msg_end` is high for exactly the one cycle after that '=' is accepted. Any later '=' has no effect.
- R7: Any character that is neither an alphabet character nor '=' sets `err` and is dropped, leaving the decoded bytes unchanged.
- R8: A data character accepted after the first '=' sets `err`, is dropped, and produces no byte.
- R9: Once reset has been released, the block comes up with `out_valid`, `msg_end` and `err` low and `in_ready` high.
- R10: `err` never falls except by reset, and `msg_end` pulses at most once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Character offered |
| in_char | input | 8 | ASCII character code |
| in_ready | output | 1 | Character taken at this edge when high together with `in_valid` |
| out_valid | output | 1 | Decoded byte available |
| out_byte | output | 8 | Decoded byte |
| out_ready | input | 1 | Consumer takes the byte |
| msg_end | output | 1 | One-cycle pulse after the first padding character |
| err | output | 1 | Sticky error flag |

## Verification
All 256 character codes are each sent before an 'A' and a '=', so one run separates the alphabet values from padding and from illegal codes. The same run also shows that an illegal code leaves the following byte untouched. A fixed text with a known decoding pins the bit order. Generated messages of length 1 to 40 sweep every residue count from 0 to 7 at padding time, which is where off-by-one handling in the accumulator would show. Those messages run under a stuttering output ready, and comparing the result with an arithmetic bit-string model exposes any bit lost or repeated under backpressure. Runs that place data after padding, and that repeat padding, separate the error case from the ignored case.

// File: rtl/b32_pkg.sv
package b32_pkg;
  localparam int CHAR_BITS = 8;
  localparam int GROUP_BITS = 5;
  localparam int OCTET_BITS = 8;
  // residue of up to 7 bits plus one fresh group
  localparam int HOLD_BITS = OCTET_BITS - 1 + GROUP_BITS;

  localparam logic [7:0] ASC_UP_A = 8'h41;
  localparam logic [7:0] ASC_UP_Z = 8'h5A;
  localparam logic [7:0] ASC_DIG2 = 8'h32;
  localparam logic [7:0] ASC_DIG7 = 8'h37;
  localparam logic [7:0] ASC_PAD = 8'h3D;
  localparam int LETTER_COUNT = 26;
endpackage

// File: rtl/b32_rst_sync.sv
module b32_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/b32_symbol_map.sv
module b32_symbol_map
  import b32_pkg::*;
#(
  parameter int CHAR_W = CHAR_BITS,
  parameter int SYM_W = GROUP_BITS
) (
  input  logic [CHAR_W-1:0] ch,
  output logic              is_data,
  output logic              is_pad,
  output logic [SYM_W-1:0]  value
);
  logic is_letter;
  logic is_digit;

  always_comb begin
    is_letter = (ch >= CHAR_W'(ASC_UP_A)) && (ch <= CHAR_W'(ASC_UP_Z));
    is_digit  = (ch >= CHAR_W'(ASC_DIG2)) && (ch <= CHAR_W'(ASC_DIG7));
    is_pad    = (ch == CHAR_W'(ASC_PAD));
    is_data   = is_letter || is_digit;
    if (is_letter) begin
      value = SYM_W'(ch - CHAR_W'(ASC_UP_A));
    end else if (is_digit) begin
      value = SYM_W'(ch - CHAR_W'(ASC_DIG2) + CHAR_W'(LETTER_COUNT));
    end else begin
      value = '0;
    end
  end
endmodule

// File: rtl/b32_bit_packer.sv
module b32_bit_packer #(
  parameter int SYM_W = 5,
  parameter int OUT_W = 8,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SYM_W-1:0] sym,
  input  logic             pop,
  input  logic             flush,
  output logic             word_valid,
  output logic [OUT_W-1:0] word
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_pop, shamt;
  logic             en;

  assign word_valid = (cnt_q >= CNT_W'(OUT_W));
  assign shamt = cnt_q - CNT_W'(OUT_W);
  assign word = OUT_W'(acc_q >> shamt);
  assign en = push || pop || flush;

  always_comb begin
    cnt_pop = pop ? (cnt_q - CNT_W'(OUT_W)) : cnt_q;
    cnt_d = cnt_pop;
    acc_d = acc_q;
    if (flush) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (push) begin
      acc_d = {acc_q[ACC_W-SYM_W-1:0], sym};
      cnt_d = cnt_pop + CNT_W'(SYM_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/b32_term_ctrl.sv
module b32_term_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic is_data,
  input  logic is_pad,
  output logic push,
  output logic flush,
  output logic end_pulse,
  output logic err_flag
);
  logic pad_q, pad_d;
  logic err_q, err_d;
  logic end_q, end_d;
  logic bad;

  always_comb begin
    push  = take && is_data && !pad_q;
    flush = take && is_pad && !pad_q;
    bad   = take && ((!is_data && !is_pad) || (is_data && pad_q));
    pad_d = pad_q || flush;
    err_d = err_q || bad;
    end_d = flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= 1'b0;
      err_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      pad_q <= pad_d;
      err_q <= err_d;
      end_q <= end_d;
    end
  end

  assign end_pulse = end_q;
  assign err_flag = err_q;
endmodule

// File: rtl/b32_stream_decoder.sv
module b32_stream_decoder
  import b32_pkg::*;
#(
  parameter int CHAR_W = CHAR_BITS,
  parameter int SYM_W = GROUP_BITS,
  parameter int BYTE_W = OCTET_BITS,
  parameter int ACC_W = HOLD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              out_ready,
  output logic              msg_end,
  output logic              err
);
  logic             rst_sync_n;
  logic             sym_data, sym_pad;
  logic [SYM_W-1:0] sym_val;
  logic             take, push, pop, flush;

  b32_rst_sync rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  b32_symbol_map #(.CHAR_W(CHAR_W), .SYM_W(SYM_W)) map_i (
    .ch(in_char), .is_data(sym_data), .is_pad(sym_pad), .value(sym_val)
  );

  assign pop = out_valid && out_ready;
  assign in_ready = rst_sync_n && (!out_valid || out_ready);
  assign take = in_valid && in_ready;

  b32_term_ctrl term_i (
    .clk(clk), .rst_n(rst_sync_n), .take(take),
    .is_data(sym_data), .is_pad(sym_pad),
    .push(push), .flush(flush), .end_pulse(msg_end), .err_flag(err)
  );

  b32_bit_packer #(.SYM_W(SYM_W), .OUT_W(BYTE_W), .ACC_W(ACC_W)) pack_i (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .sym(sym_val),
    .pop(pop), .flush(flush), .word_valid(out_valid), .word(out_byte)
  );
endmodule

// File: rtl/b32_stream_decoder_chk.sv
module b32_stream_decoder_chk #(
  parameter int CHAR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CHAR_W-1:0] in_char,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_ready,
  input logic              msg_end,
  input logic              err
);
  logic seen_end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_end_q <= 1'b0;
    end else if (msg_end) begin
      seen_end_q <= 1'b1;
    end
  end

  // R4
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R5
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  end_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> !msg_end);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  end_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> !seen_end_q);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(in_valid && in_ready));
endmodule

bind b32_stream_decoder b32_stream_decoder_chk #(.CHAR_W(CHAR_W), .BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/b32_stream_decoder_tb.sv
module b32_stream_decoder_tb_top;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_char;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_ready;
  logic       msg_end;
  logic       err;

  int n_chk;
  int n_bad;
  int cyc;
  bit stall_mode;
  bit monitor_on;

  logic [7:0] tx [0:63];
  int         ntx;
  logic [7:0] rx [0:63];
  int         nrx;
  int         nend;
  logic [7:0] ex [0:63];
  int         nex;

  b32_stream_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .in_ready(in_ready), .out_valid(out_valid), .out_byte(out_byte),
    .out_ready(out_ready), .msg_end(msg_end), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      report();
    end
  end

  always @(negedge clk) begin
    out_ready = stall_mode ? ((cyc % 5) != 1 && (cyc % 5) != 3) : 1'b1;
    #1;
    if (monitor_on) begin
      if (out_valid && out_ready && nrx < 64) begin
        rx[nrx] = out_byte;
        nrx = nrx + 1;
      end
      if (msg_end) nend = nend + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // -1 illegal, -2 padding, else the 5-bit value
  function automatic int char_val(input logic [7:0] c);
    if (c >= 8'h41 && c <= 8'h5A) return int'(c) - 65;
    if (c >= 8'h32 && c <= 8'h37) return int'(c) - 50 + 26;
    if (c == 8'h3D) return -2;
    return -1;
  endfunction

  task automatic do_reset;
    monitor_on = 1'b0;
    in_valid = 1'b0;
    in_char = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nrx = 0;
    nend = 0;
    monitor_on = 1'b1;
  endtask

  task automatic send_char(input logic [7:0] c);
    bit ok;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_char = c;
      #1.5;
      ok = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_msg;
    int acc;
    int bits;
    int v;
    bit padded;
    bit exp_err;
    int exp_end;
    acc = 0; bits = 0; padded = 0; exp_err = 0; exp_end = 0; nex = 0;
    for (int i = 0; i < ntx; i++) begin
      v = char_val(tx[i]);
      if (v == -2) begin
        if (!padded) begin
          padded = 1; bits = 0; exp_end = 1;
        end
      end else if (v == -1 || padded) begin
        exp_err = 1;
      end else begin
        acc = ((acc << 5) | v) & 32'hFFF;
        bits = bits + 5;
        if (bits >= 8) begin
          ex[nex] = 8'((acc >> (bits - 8)) & 8'hFF);
          nex = nex + 1;
          bits = bits - 8;
        end
      end
    end
    do_reset();
    for (int i = 0; i < ntx; i++) send_char(tx[i]);
    repeat (40) @(negedge clk);
    check(nrx == nex, "R3 byte count", nrx, nex);
    for (int i = 0; i < nex && i < nrx; i++)
      check(rx[i] == ex[i], "R1/R2/R5 byte value", int'(rx[i]), int'(ex[i]));
    check(err == exp_err, "R7/R8 err", int'(err), int'(exp_err));
    check(nend == exp_end, "R6/R10 msg_end count", nend, exp_end);
  endtask

  initial begin
    int seed;
    int npad;
    n_chk = 0; n_bad = 0; cyc = 0; nrx = 0; nend = 0;
    stall_mode = 1'b0;
    monitor_on = 1'b0;
    do_reset();
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    check(err == 1'b0, "R9 err", int'(err), 0);
    check(msg_end == 1'b0, "R9 msg_end", int'(msg_end), 0);

    // R1 R7: every code, then 'A' and '='
    for (int c = 0; c < 256; c++) begin
      tx[0] = 8'(c); tx[1] = 8'h41; tx[2] = 8'h3D; ntx = 3;
      run_msg();
    end
    // R7: illegal code between data leaves bytes untouched
    tx[0] = 8'h42; tx[1] = 8'h61; tx[2] = 8'h41; tx[3] = 8'h3D; ntx = 4;
    run_msg();
    check(nrx == 1 && rx[0] == 8'h08, "R7 dropped char", int'(rx[0]), 8);

    // R2: "MZXW6===" decodes to "foo"
    tx[0] = "M"; tx[1] = "Z"; tx[2] = "X"; tx[3] = "W"; tx[4] = "6";
    tx[5] = "="; tx[6] = "="; tx[7] = "="; ntx = 8;
    run_msg();
    check(nrx == 3 && rx[0] == 8'h66 && rx[1] == 8'h6F && rx[2] == 8'h6F,
          "R2 known text", int'(rx[0]), 8'h66);

    // R3 R5 R6: lengths 1..40 under output stalls
    stall_mode = 1'b1;
    seed = 7;
    for (int len = 1; len <= 40; len++) begin
      for (int i = 0; i < len; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
        tx[i] = (((seed >> 8) % 32) < 26) ? 8'(65 + ((seed >> 8) % 32))
                                          : 8'(50 + ((seed >> 8) % 32) - 26);
      end
      npad = len % 3;
      for (int k = 0; k < npad; k++) tx[len + k] = 8'h3D;
      ntx = len + npad;
      run_msg();
    end

    // R8: data after padding
    tx[0] = "M"; tx[1] = "Z"; tx[2] = "="; tx[3] = "Q"; tx[4] = "="; ntx = 5;
    run_msg();
    check(err == 1'b1, "R8 data after pad", int'(err), 1);

    stall_mode = 1'b0;
    report();
  end
endmodule